// File: doc/BRIEF.md
# Multi-Converter Ramp Pattern Checker

This block watches the sample words coming out of a converter receive path while a ramp test pattern runs. It takes M converter channels side by side on one bus, each carrying a word of several N-bit samples per valid cycle. It needs no start value. The first valid word after reset sets each converter's expected value. From then on every sample must be one greater than the sample before it, and the count wraps from the largest N-bit value back to zero.

The block also checks that all converters carry the same ramp. A converter can follow a perfectly good ramp of its own and still disagree with the others, for example because of a lane skew. That case is reported through the summary flag but does not count as a sequence break of the converter.

The outputs are sticky until reset:
- a lock flag, set once the first valid word has been seen;
- a per-converter sequence-break vector;
- a global error flag.

A test harness typically releases reset once the link is aligned and then reads the flags after the pattern has run.

Top module: `ramp_pattern_checker`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, `locked_o`, `err_o` and every bit of `conv_err_o` are 0.
- R2: The first word accepted with `valid_i` high after reset seeds every converter's expected value. The value of its sample 0 is never an error. `locked_o` is 1 from the cycle after that word and stays 1 until reset.
- R3: For every later accepted word, sample 0 of converter c must equal the last sample of converter c's previous accepted word plus one. Otherwise bit c of `conv_err_o` is set.
- R4: All increments are modulo 2^N: the sample after 2^N-1 must be 0, and that wrap is not an error.
- R5: Within a word, sample k of converter c sits at bits [c*W + k*N +: N] of `data_i`, with W = S*WIDTH_MULP*N. Each sample k ≥ 1 must equal sample k-1 plus one. This applies to the seeding word as well, and a break sets bit c of `conv_err_o`.
- R6: A cycle with `valid_i` low has no effect: the flags do not change, and the expected value does not advance.
- R7: On every accepted word, the W-bit words of all converters must be identical. A difference sets `err_o` but leaves `conv_err_o` unchanged.
- R8: `err_o` is set whenever any bit of `conv_err_o` is set or an R7 mismatch occurs. Every flag stays set until reset.
- R9: The flags for a word accepted at one rising edge appear at the outputs directly after that edge, with one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | `data_i` carries a word for every converter this cycle |
| data_i | input | M*S*WIDTH_MULP*N | All converter words, converter 0 in the lowest bits |
| locked_o | output | 1 | The expected values have been seeded |
| err_o | output | 1 | Sticky summary error, sequence or cross-converter |
| conv_err_o | output | M | Sticky sequence-break flag per converter |

## Verification
The assertions take two things for granted. Reset is held for at least one clock edge. `valid_i` and `data_i` are stable around the rising edge, which the bench ensures by driving on the falling edge only. They do not assume anything about the data values: the flag relations they state must hold for any contents of `data_i`. The stimulus therefore mixes clean ramps, wraps, and deliberately broken, offset or garbage words. It restarts from reset before each scenario so that earlier sticky flags do not hide later ones.

// File: rtl/rampchk_pkg.sv
`timescale 1ns/1ps
package rampchk_pkg;
   // samples carried by one converter in one valid cycle
   function automatic int unsigned samples_per_word(input int unsigned s,
                                                    input int unsigned mulp);
      return s * mulp;
   endfunction
endpackage

// File: rtl/rampchk_lane.sv
`timescale 1ns/1ps
// Sequence check for one converter: intra-word steps and word-to-word continuity.
module rampchk_lane #(
   parameter int unsigned N = 16,
   parameter int unsigned K = 2
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           vld_i,
   input  logic           seeded_i,
   input  logic [K*N-1:0] word_i,
   output logic           bad_o
);
   logic [N-1:0] smp [K];
   logic [N-1:0] exp_q;
   logic         intra_ok;
   logic         start_ok;

   for (genvar k = 0; k < K; k++) begin : g_unpack
      assign smp[k] = word_i[k*N +: N];
   end

   if (K > 1) begin : g_multi
      logic [K-2:0] step_ok;
      for (genvar k = 1; k < K; k++) begin : g_step
         assign step_ok[k-1] = (smp[k] == smp[k-1] + N'(1));
      end
      assign intra_ok = &step_ok;
   end else begin : g_single
      assign intra_ok = 1'b1;
   end

   // next word must begin one above the last sample of this word
   always_ff @(posedge clk_i) begin
      if (!rst_ni)    exp_q <= '0;
      else if (vld_i) exp_q <= smp[K-1] + N'(1);
   end

   assign start_ok = !seeded_i || (smp[0] == exp_q);
   assign bad_o    = vld_i && !(start_ok && intra_ok);
endmodule

// File: rtl/rampchk_xcmp.sv
`timescale 1ns/1ps
// Compares every converter word against converter 0.
module rampchk_xcmp #(
   parameter int unsigned M = 2,
   parameter int unsigned W = 32
) (
   input  logic           vld_i,
   input  logic [M*W-1:0] data_i,
   output logic           mis_o
);
   if (M > 1) begin : g_cmp
      logic [M-2:0] diff;
      for (genvar i = 1; i < M; i++) begin : g_pair
         assign diff[i-1] = (data_i[i*W +: W] != data_i[0 +: W]);
      end
      assign mis_o = vld_i && (|diff);
   end else begin : g_none
      assign mis_o = 1'b0;
   end
endmodule

// File: rtl/ramp_pattern_checker.sv
`timescale 1ns/1ps
module ramp_pattern_checker #(
   parameter int unsigned M          = 2,
   parameter int unsigned N          = 16,
   parameter int unsigned S          = 1,
   parameter int unsigned WIDTH_MULP = 2
) (
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  logic                               valid_i,
   input  logic [M*S*WIDTH_MULP*N-1:0]        data_i,
   output logic                               locked_o,
   output logic                               err_o,
   output logic [M-1:0]                       conv_err_o
);
   import rampchk_pkg::*;

   localparam int unsigned K = samples_per_word(S, WIDTH_MULP);
   localparam int unsigned W = K * N;

   if (M < 1) begin : g_chk_m
      $error("ramp_pattern_checker: M must be at least 1");
   end
   if (N < 2) begin : g_chk_n
      $error("ramp_pattern_checker: N must be at least 2");
   end
   if (K < 1) begin : g_chk_k
      $error("ramp_pattern_checker: S*WIDTH_MULP must be at least 1");
   end

   logic         locked_q;
   logic         err_q;
   logic [M-1:0] conv_err_q;
   logic [M-1:0] bad_vec;
   logic         mis;

   for (genvar c = 0; c < M; c++) begin : g_lane
      rampchk_lane #(.N(N), .K(K)) i_lane (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .vld_i    (valid_i),
         .seeded_i (locked_q),
         .word_i   (data_i[c*W +: W]),
         .bad_o    (bad_vec[c])
      );
   end

   rampchk_xcmp #(.M(M), .W(W)) i_xcmp (
      .vld_i  (valid_i),
      .data_i (data_i),
      .mis_o  (mis)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         locked_q   <= 1'b0;
         err_q      <= 1'b0;
         conv_err_q <= '0;
      end else begin
         locked_q   <= locked_q | valid_i;
         conv_err_q <= conv_err_q | bad_vec;
         err_q      <= err_q | (|bad_vec) | mis;
      end
   end

   assign locked_o   = locked_q;
   assign err_o      = err_q;
   assign conv_err_o = conv_err_q;
endmodule

// File: rtl/ramp_pattern_checker_sva.sv
`timescale 1ns/1ps
module ramp_pattern_checker_sva #(
   parameter int unsigned M = 2
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         valid_i,
   input logic         locked_o,
   input logic         err_o,
   input logic [M-1:0] conv_err_o
);
   // R8: no per-converter flag ever clears
   a_r8_conv_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((conv_err_o & $past(conv_err_o)) == $past(conv_err_o)));

   // R8: summary flag stays set
   a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);

   // R8: a sequence break is always reflected in the summary
   a_r8_err_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_err_o != '0) |-> err_o);

   // R2: lock never drops
   a_r2_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o |=> locked_o);

   // R2: nothing can be flagged before seeding
   a_r2_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !locked_o |-> (!err_o && conv_err_o == '0));

   // R6: an idle cycle changes no flag
   a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(err_o) && $stable(conv_err_o) && $stable(locked_o)));

   // R9: lock rises only after an accepted word
   a_r9_lock_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_o) |-> $past(valid_i));
endmodule

bind ramp_pattern_checker ramp_pattern_checker_sva #(.M(M)) i_sva (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .valid_i    (valid_i),
   .locked_o   (locked_o),
   .err_o      (err_o),
   .conv_err_o (conv_err_o)
);

// File: tb/test_ramp_pattern_checker.sv
`timescale 1ns/1ps
module test_ramp_pattern_checker;
   localparam int M = 2;
   localparam int N = 16;
   localparam int K = 2;
   localparam int W = K * N;

   typedef struct {
      logic         lk;
      logic         er;
      logic [M-1:0] ce;
      string        tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             valid = 1'b0;
   logic [M*W-1:0]   data = '0;
   logic             locked;
   logic             err;
   logic [M-1:0]     conv_err;

   int checks = 0;
   int errors = 0;
   exp_t sbq[$];

   logic [N-1:0] m_exp [M];
   bit           m_seed;
   bit           m_err;
   logic [M-1:0] m_ce;

   ramp_pattern_checker #(.M(M), .N(N), .S(1), .WIDTH_MULP(2)) i_ramp_pattern_checker (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
      .locked_o(locked), .err_o(err), .conv_err_o(conv_err));

   always #2.5 clk = ~clk;

   function automatic logic [W-1:0] ramp(input logic [N-1:0] s0);
      return {s0 + N'(1), s0};
   endfunction

   function automatic logic [W-1:0] pair(input logic [N-1:0] a, input logic [N-1:0] b);
      return {b, a};
   endfunction

   task automatic check(input string tag, input logic lk, input logic er, input logic [M-1:0] ce);
      checks++;
      if (locked !== lk || err !== er || conv_err !== ce) begin
         errors++;
         $display("FAIL %s: locked/err/conv_err got %b/%b/%b expected %b/%b/%b",
                  tag, locked, err, conv_err, lk, er, ce);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; valid = 1'b0; data = '0;
      repeat (2) @(negedge clk);
      check("R1 in reset", 1'b0, 1'b0, '0);
      m_seed = 0; m_err = 0; m_ce = '0;
      for (int c = 0; c < M; c++) m_exp[c] = '0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 1'b0, 1'b0, '0);
   endtask

   // driver: applies one cycle and pushes the flags the requirements predict
   task automatic drive(input bit v, input logic [M*W-1:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      valid = v; data = d;
      if (v) begin
         for (int c = 0; c < M; c++) begin
            logic [W-1:0] wd;
            logic [N-1:0] s [K];
            bit bad;
            wd = d[c*W +: W];
            for (int k = 0; k < K; k++) s[k] = wd[k*N +: N];
            bad = m_seed && (s[0] != m_exp[c]);
            for (int k = 1; k < K; k++) if (s[k] != s[k-1] + N'(1)) bad = 1;
            m_exp[c] = s[K-1] + N'(1);
            if (bad) begin m_ce[c] = 1'b1; m_err = 1; end
            if (wd != d[W-1:0]) m_err = 1;
         end
         m_seed = 1;
      end
      e.lk = m_seed; e.er = m_err; e.ce = m_ce; e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: compares results just after the edge that registers them (R9)
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(e.tag, e.lk, e.er, e.ce);
         end
      end
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [N-1:0] v0;
      // R6: idle garbage before seeding
      do_reset();
      drive(0, 64'hDEAD_BEEF_1234_5678, "R6 idle before seed");
      drive(0, 64'h0000_0001_0000_0007, "R6 idle before seed");
      // R2, R3, R9: clean ramp from arbitrary seed
      v0 = 16'h1234;
      for (int i = 0; i < 5; i++) begin
         drive(1, {ramp(v0), ramp(v0)}, "R2/R3 clean ramp");
         v0 = v0 + N'(2);
      end
      // R6: garbage while idle must not advance the expected value
      drive(0, 64'hFFFF_0000_AAAA_5555, "R6 idle mid ramp");
      drive(0, '0, "R6 idle mid ramp");
      for (int i = 0; i < 3; i++) begin
         drive(1, {ramp(v0), ramp(v0)}, "R3 resume after idle");
         v0 = v0 + N'(2);
      end

      // R4: wraps at word boundary and inside a word
      do_reset();
      drive(1, {pair(16'hFFFC, 16'hFFFD), pair(16'hFFFC, 16'hFFFD)}, "R4 seed near max");
      drive(1, {pair(16'hFFFE, 16'hFFFF), pair(16'hFFFE, 16'hFFFF)}, "R4 reach max");
      drive(1, {pair(16'h0000, 16'h0001), pair(16'h0000, 16'h0001)}, "R4 wrap between words");
      do_reset();
      drive(1, {pair(16'hFFFF, 16'h0000), pair(16'hFFFF, 16'h0000)}, "R4 wrap inside word");
      drive(1, {pair(16'h0001, 16'h0002), pair(16'h0001, 16'h0002)}, "R4 after wrap");

      // R3, R8: converter 0 skips a value, then stays sticky
      do_reset();
      drive(1, {ramp(16'h0100), ramp(16'h0100)}, "R3 seed");
      drive(1, {ramp(16'h0102), ramp(16'h0103)}, "R3 conv0 jump");
      drive(1, {ramp(16'h0104), ramp(16'h0104)}, "R8 sticky after recovery");
      drive(1, {ramp(16'h0106), ramp(16'h0106)}, "R8 sticky after recovery");

      // R5: intra-word break on the seeding word, both converters
      do_reset();
      drive(1, {pair(16'h0005, 16'h0007), pair(16'h0005, 16'h0007)}, "R5 intra break");
      // R5: sample order, reversed halves in converter 1 only
      do_reset();
      drive(1, {pair(16'h0021, 16'h0020), ramp(16'h0020)}, "R5 reversed order");

      // R7: each converter a valid ramp, but offset from each other
      do_reset();
      drive(1, {ramp(16'h0043), ramp(16'h0040)}, "R7 offset ramps");
      drive(1, {ramp(16'h0045), ramp(16'h0042)}, "R7 offset ramps");
      drive(0, '0, "R6 idle keeps flags");

      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule